// File: doc/BRIEF.md
# Double-Buffered Reference Divider

This block divides a reference clock by a programmable ratio and produces one reference pulse stream for each of two phase-locked loops. Software writes a 16-bit word into a single shared staging register. Its low 13 bits hold a divide ratio and its top 3 bits select the reference-output mode. A per-loop transfer strobe copies the staged ratio into that loop's active register. A loop's reference ratio therefore changes only when its loop divider is programmed, so the reference ratio and the loop divider ratio change together. The running count is never disturbed: a new ratio starts at the loop's next terminal count.

The accepted ratios are 1 and 10 through 8191. A transfer that carries 0 or 2 through 9 is refused. The loop keeps its previous ratio and raises an error flag for that loop. Each loop has its own standby input, which silences its pulse and holds its counter preloaded.

The mode bits act at once on a write, with no transfer needed. They drive a buffered reference output that is held low, passes the reference clock through, or divides it by 2, 4, 8 or 16 with a 50% duty cycle.

Top module: `refdiv_dual`

## Requirements
- R1: With an active ratio N, loop i raises `ref_pulse[i]` once every N clock cycles. For N of 2 or more each pulse lasts one cycle. For N = 1 the pulse is high every cycle.
- R2: `fb_wr` loads `fb_data[12:0]` as the staged ratio. A write with no transfer leaves every loop's pulse period unchanged.
- R3: `xfer[i]` copies the staged ratio into loop i only, and the other loop keeps its period. If `fb_wr` and `xfer[i]` are sampled on the same edge, the transfer takes the staged value from before that edge.
- R4: A new ratio governs the interval that begins at the loop's next pulse. A transfer sampled on the very edge that raises a pulse governs the interval that starts with that pulse. A transfer sampled on any other edge leaves the interval in progress at the old length.
- R5: A transfer of a staged ratio of 0 or 2 to 9 leaves the loop's period unchanged and sets `ratio_err[i]` one cycle later. A legal transfer clears it one cycle later. Without a transfer the flag holds its value.
- R6: `fb_data[15:13]` takes effect on `ref_out` right after the `fb_wr` edge, without any transfer. The codes are: 0 = held low, 1 = reference clock passed through, 2 = divide by 2, 3 = divide by 4, 4 = divide by 8, and 5, 6 or 7 = divide by 16.
- R7: In the divide-by-2^k modes, `ref_out` is a square wave with a period of 2^k cycles, high for exactly half of each period.
- R8: While `stby[i]` is sampled high, `ref_pulse[i]` is low from the next cycle on, and transfers still apply. After release, with N the ratio then active, the first pulse is high after the N-th edge, counting the first edge that samples `stby[i]` low as the first.
- R9: Reset clears all pulses and error flags, sets both loops and the staged ratio to 10, and selects mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fb_wr | input | 1 | Write strobe for the staging register |
| fb_data | input | 16 | Mode code [15:13] and ratio [12:0] |
| xfer | input | 2 | Per-loop transfer strobe, staged ratio to active |
| stby | input | 2 | Per-loop standby |
| ref_pulse | output | 2 | Per-loop reference pulse |
| ratio_err | output | 2 | Per-loop illegal-ratio flag |
| ref_out | output | 1 | Buffered, divided reference clock |

## Verification
A transfer and a terminal count can fall on the same clock edge. The bench provokes this by counting cycles from an observed pulse and raising the transfer so that it is sampled exactly on the edge that produces the next pulse. The case is judged correct when that pulse still arrives on time and the gap after it already has the new length. A mid-interval transfer serves as the contrasting case: its gap must keep the old length. The second collision, a staging write sampled on the same edge as a transfer, is judged by the measured period, which must show the older staged value.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    // Width of the reference-output mode code carried above the ratio field
    localparam int unsigned MODE_W   = 3;
    // Smallest programmable ratio above the pass-through ratio of one
    localparam int unsigned PROG_MIN = 10;

    typedef enum logic [MODE_W-1:0] {
        OUT_OFF   = 3'd0,
        OUT_DIV1  = 3'd1,
        OUT_DIV2  = 3'd2,
        OUT_DIV4  = 3'd3,
        OUT_DIV8  = 3'd4,
        OUT_DIV16 = 3'd5
    } out_mode_e;

    function automatic logic ratio_ok(input int unsigned r);
        return (r == 1) || (r >= PROG_MIN);
    endfunction

endpackage

// File: rtl/refdiv_wbuf.sv
module refdiv_wbuf
    import refdiv_pkg::*;
#(
    parameter int unsigned RATIO_W     = 13,
    parameter int unsigned RESET_RATIO = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr,
    input  logic [RATIO_W+MODE_W-1:0]   data,
    output logic [RATIO_W-1:0]          fb_ratio,
    output logic [MODE_W-1:0]           out_mode
);

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic [MODE_W-1:0]  mode;
    } wbuf_t;

    wbuf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.ratio = data[RATIO_W-1:0];
            st_d.mode  = data[RATIO_W+MODE_W-1:RATIO_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ratio <= RATIO_W'(RESET_RATIO);
            st_q.mode  <= OUT_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    assign fb_ratio = st_q.ratio;
    assign out_mode = st_q.mode;

endmodule

// File: rtl/refdiv_loop.sv
module refdiv_loop
    import refdiv_pkg::*;
#(
    parameter int unsigned RATIO_W     = 13,
    parameter int unsigned RESET_RATIO = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               xfer,
    input  logic               stby,
    input  logic [RATIO_W-1:0] fb_ratio,
    output logic               pulse,
    output logic               err
);

    localparam int unsigned PAD_W = 32 - RATIO_W;

    typedef struct packed {
        logic [RATIO_W-1:0] act;    // second buffer: ratio in force
        logic [RATIO_W-1:0] cnt;    // down counter, terminal at zero
        logic               pulse;
        logic               err;
    } loop_t;

    loop_t s_d, s_q;
    logic  legal;
    logic  tc;

    always_comb begin
        s_d   = s_q;
        legal = ratio_ok({{PAD_W{1'b0}}, fb_ratio});
        tc    = (s_q.cnt == '0);

        // transfer from the shared staging register
        if (xfer) begin
            if (legal) begin
                s_d.act = fb_ratio;
                s_d.err = 1'b0;
            end else begin
                s_d.err = 1'b1;
            end
        end

        // counting; reload picks up the second buffer as updated this edge
        if (stby) begin
            s_d.cnt   = s_d.act - RATIO_W'(1);
            s_d.pulse = 1'b0;
        end else if (tc) begin
            s_d.cnt   = s_d.act - RATIO_W'(1);
            s_d.pulse = 1'b1;
        end else begin
            s_d.cnt   = s_q.cnt - RATIO_W'(1);
            s_d.pulse = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.act   <= RATIO_W'(RESET_RATIO);
            s_q.cnt   <= RATIO_W'(RESET_RATIO - 1);
            s_q.pulse <= 1'b0;
            s_q.err   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pulse = s_q.pulse;
    assign err   = s_q.err;

endmodule

// File: rtl/refdiv_outdiv.sv
module refdiv_outdiv
    import refdiv_pkg::*;
#(
    parameter int unsigned OUT_STAGES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    output logic              ref_out
);

    localparam int unsigned SEL_W = $clog2(OUT_STAGES + 1);
    localparam int unsigned TAP_N = 1 << SEL_W;

    typedef struct packed {
        logic [OUT_STAGES-1:0] div;
    } odiv_t;

    odiv_t             o_d, o_q;
    logic [TAP_N-1:0]  taps;
    logic [MODE_W-1:0] m1;
    logic [SEL_W-1:0]  sel;

    always_comb begin
        o_d     = o_q;
        o_d.div = o_q.div + OUT_STAGES'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q.div <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    // tap 0 is the undivided clock, tap k is the 2^k ripple bit
    for (genvar j = 0; j < TAP_N; j++) begin : g_tap
        if (j == 0) begin : g_pass
            assign taps[j] = clk;
        end else if (j <= OUT_STAGES) begin : g_bit
            assign taps[j] = o_q.div[j-1];
        end else begin : g_clamp
            assign taps[j] = o_q.div[OUT_STAGES-1];
        end
    end

    always_comb begin
        m1 = mode - MODE_W'(1);
        if (int'(m1) > int'(OUT_STAGES)) begin
            sel = SEL_W'(OUT_STAGES);
        end else begin
            sel = SEL_W'(m1);
        end
        if (mode == OUT_OFF) begin
            ref_out = 1'b0;
        end else begin
            ref_out = taps[sel];
        end
    end

endmodule

// File: rtl/refdiv_dual.sv
module refdiv_dual
    import refdiv_pkg::*;
#(
    parameter int unsigned RATIO_W     = 13,
    parameter int unsigned NUM_LOOPS   = 2,
    parameter int unsigned OUT_STAGES  = 4,
    parameter int unsigned RESET_RATIO = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fb_wr,
    input  logic [RATIO_W+MODE_W-1:0]     fb_data,
    input  logic [NUM_LOOPS-1:0]          xfer,
    input  logic [NUM_LOOPS-1:0]          stby,
    output logic [NUM_LOOPS-1:0]          ref_pulse,
    output logic [NUM_LOOPS-1:0]          ratio_err,
    output logic                          ref_out
);

    logic [RATIO_W-1:0] fb_ratio;
    logic [MODE_W-1:0]  out_mode;

    refdiv_wbuf #(
        .RATIO_W     (RATIO_W),
        .RESET_RATIO (RESET_RATIO)
    ) u_wbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (fb_wr),
        .data     (fb_data),
        .fb_ratio (fb_ratio),
        .out_mode (out_mode)
    );

    for (genvar i = 0; i < NUM_LOOPS; i++) begin : g_loop
        refdiv_loop #(
            .RATIO_W     (RATIO_W),
            .RESET_RATIO (RESET_RATIO)
        ) u_loop (
            .clk      (clk),
            .rst_n    (rst_n),
            .xfer     (xfer[i]),
            .stby     (stby[i]),
            .fb_ratio (fb_ratio),
            .pulse    (ref_pulse[i]),
            .err      (ratio_err[i])
        );
    end

    refdiv_outdiv #(
        .OUT_STAGES (OUT_STAGES)
    ) u_outdiv (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (out_mode),
        .ref_out (ref_out)
    );

endmodule

// File: rtl/refdiv_chk.sv
module refdiv_chk
    import refdiv_pkg::*;
#(
    parameter int unsigned RATIO_W   = 13,
    parameter int unsigned NUM_LOOPS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LOOPS-1:0] xfer,
    input logic [NUM_LOOPS-1:0] stby,
    input logic [NUM_LOOPS-1:0] ref_pulse,
    input logic [NUM_LOOPS-1:0] ratio_err,
    input logic [RATIO_W-1:0]   fb_ratio,
    input logic [MODE_W-1:0]    out_mode,
    input logic                 ref_out
);

    localparam int unsigned PAD_W = 32 - RATIO_W;

    for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_chk
        assert_stby_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
            stby[g] |=> !ref_pulse[g]);

        assert_bad_ratio_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (xfer[g] && !ratio_ok({{PAD_W{1'b0}}, fb_ratio})) |=> ratio_err[g]);

        assert_good_ratio_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (xfer[g] && ratio_ok({{PAD_W{1'b0}}, fb_ratio})) |=> !ratio_err[g]);

        assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !xfer[g] |=> $stable(ratio_err[g]));
    end

    assert_off_mode_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == OUT_OFF) |-> !ref_out);

    assert_reset_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ratio_err == '0 && ref_pulse == '0));

endmodule

bind refdiv_dual refdiv_chk #(
    .RATIO_W   (RATIO_W),
    .NUM_LOOPS (NUM_LOOPS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer      (xfer),
    .stby      (stby),
    .ref_pulse (ref_pulse),
    .ratio_err (ratio_err),
    .fb_ratio  (fb_ratio),
    .out_mode  (out_mode),
    .ref_out   (ref_out)
);

// File: tb/refdiv_dual_tb_top.sv
module refdiv_dual_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fb_wr = 1'b0;
    logic [15:0] fb_data = '0;
    logic [1:0]  xfer = '0;
    logic [1:0]  stby = '0;
    logic [1:0]  ref_pulse;
    logic [1:0]  ratio_err;
    logic        ref_out;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    refdiv_dual dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fb_wr     (fb_wr),
        .fb_data   (fb_data),
        .xfer      (xfer),
        .stby      (stby),
        .ref_pulse (ref_pulse),
        .ratio_err (ratio_err),
        .ref_out   (ref_out)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1;
            miscompares++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic stage(input int ratio, input int code);
        fb_wr   = 1'b1;
        fb_data = {code[2:0], ratio[12:0]};
        tick();
        fb_wr   = 1'b0;
    endtask

    task automatic load(input int l, input int ratio, input int code);
        stage(ratio, code);
        xfer[l] = 1'b1;
        tick();
        xfer[l] = 1'b0;
    endtask

    task automatic wait_pulse(input int l);
        int n = 0;
        while (!ref_pulse[l] && n < 20000) begin
            tick();
            n++;
        end
    endtask

    task automatic gap_of(input int l, output int g);
        wait_pulse(l);
        g = 0;
        do begin
            tick();
            g++;
        end while (!ref_pulse[l] && g < 20000);
    endtask

    initial begin
        int g;
        int n;
        int k;
        int trans;
        int highs;
        logic prev;

        repeat (3) tick();
        // R9: reset state
        chk("R9 pulse at reset", int'(ref_pulse), 0);
        chk("R9 err at reset", int'(ratio_err), 0);
        chk("R9 ref_out at reset", int'(ref_out), 0);
        rst_n = 1'b1;
        tick();
        chk("R9 pulse after release", int'(ref_pulse), 0);
        chk("R9 err after release", int'(ratio_err), 0);
        gap_of(0, g);
        chk("R9 loop0 reset ratio", g, 10);
        gap_of(1, g);
        chk("R9 loop1 reset ratio", g, 10);

        // R1 sweep over legal ratios on loop 0, loop 1 parked at 17
        load(1, 17, 0);
        for (int r = 0; r <= 33; r++) begin
            int ratio;
            ratio = (r == 0) ? 1 : ((r == 33) ? 8191 : r + 9);
            load(0, ratio, 0);
            gap_of(0, g);
            chk($sformatf("R1 period ratio %0d", ratio), g, ratio);
            if (ratio >= 2) begin
                tick();
                chk($sformatf("R1 one-cycle width ratio %0d", ratio), int'(ref_pulse[0]), 0);
            end
        end
        gap_of(1, g);
        chk("R3 loop1 untouched by loop0 transfers", g, 17);

        // R2: staging write without transfer changes nothing
        load(0, 20, 0);
        stage(30, 0);
        gap_of(0, g);
        chk("R2 staged write ignored", g, 20);
        gap_of(0, g);
        chk("R2 staged write ignored again", g, 20);

        // R3: write and transfer on the same edge take the older staged value
        fb_wr = 1'b1;
        fb_data = {3'd0, 13'd15};
        xfer[0] = 1'b1;
        tick();
        fb_wr = 1'b0;
        xfer[0] = 1'b0;
        gap_of(0, g);
        chk("R3 same-edge write and transfer", g, 30);
        xfer[0] = 1'b1;
        tick();
        xfer[0] = 1'b0;
        gap_of(0, g);
        chk("R3 later transfer of new value", g, 15);
        gap_of(1, g);
        chk("R3 loop1 still 17", g, 17);

        // R5: illegal ratios refused, flag set, held, cleared
        for (int b = 0; b <= 9; b++) begin
            if (b != 1) begin
                load(0, b, 0);
                chk($sformatf("R5 err set for ratio %0d", b), int'(ratio_err[0]), 1);
                chk($sformatf("R5 loop1 err clear for ratio %0d", b), int'(ratio_err[1]), 0);
                gap_of(0, g);
                chk($sformatf("R5 period kept after ratio %0d", b), g, 15);
            end
        end
        repeat (5) tick();
        chk("R5 err holds without transfer", int'(ratio_err[0]), 1);
        load(0, 12, 0);
        chk("R5 err cleared by legal transfer", int'(ratio_err[0]), 0);
        gap_of(0, g);
        chk("R5 legal ratio after errors", g, 12);

        // R4: transfer on the pulse-raising edge governs the new interval
        stage(13, 0);
        wait_pulse(0);
        repeat (11) tick();
        xfer[0] = 1'b1;
        tick();
        xfer[0] = 1'b0;
        chk("R4 old interval completes on time", int'(ref_pulse[0]), 1);
        g = 0;
        do begin
            tick();
            g++;
        end while (!ref_pulse[0] && g < 20000);
        chk("R4 same-edge transfer takes this interval", g, 13);
        // R4: mid-interval transfer leaves the running interval alone
        stage(25, 0);
        wait_pulse(0);
        repeat (5) tick();
        xfer[0] = 1'b1;
        tick();
        xfer[0] = 1'b0;
        g = 6;
        while (!ref_pulse[0] && g < 20000) begin
            tick();
            g++;
        end
        chk("R4 mid-interval keeps old length", g, 13);
        gap_of(0, g);
        chk("R4 following interval uses new ratio", g, 25);

        // R8: standby silences, transfers still apply, restart timing
        load(0, 12, 0);
        stby[0] = 1'b1;
        tick();
        n = 0;
        for (int c = 0; c < 40; c++) begin
            n += int'(ref_pulse[0]);
            tick();
        end
        load(0, 14, 0);
        n += int'(ref_pulse[0]);
        chk("R8 no pulses in standby", n, 0);
        stby[0] = 1'b0;
        n = 0;
        do begin
            tick();
            n++;
        end while (!ref_pulse[0] && n < 20000);
        chk("R8 first pulse after release", n, 14);
        gap_of(0, g);
        chk("R8 period after release", g, 14);

        // R6 / R7: reference-output modes, applied by a write alone
        for (int code = 0; code < 8; code++) begin
            stage(12, code);
            tick();
            if (code == 0) begin
                highs = 0;
                for (int s = 0; s < 33; s++) begin
                    highs += int'(ref_out);
                    tick();
                end
                chk("R6 code 0 held low", highs, 0);
            end else if (code == 1) begin
                chk("R6 code 1 high phase", int'(ref_out), 1);
                @(negedge clk);
                #2;
                chk("R6 code 1 low phase", int'(ref_out), 0);
                tick();
            end else begin
                k = (code - 1 > 4) ? 4 : code - 1;
                trans = 0;
                highs = 0;
                prev = ref_out;
                for (int s = 0; s < 32; s++) begin
                    highs += int'(ref_out);
                    tick();
                    if (ref_out != prev) trans++;
                    prev = ref_out;
                end
                chk($sformatf("R7 code %0d transitions", code), trans, 64 >> k);
                chk($sformatf("R7 code %0d duty", code), highs, 16);
            end
        end
        gap_of(0, g);
        chk("R6 mode writes leave loop period", g, 14);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule